// File: doc/BRIEF.md
# Length-Prefixed Block Framer with CRC-16

This block sits between a byte-wide serial link and a command engine. Both directions use the same framing. A block starts with a length byte that counts every byte of the block. The packet bytes follow, and a two-byte CRC-16 closes the block. The CRC covers the length byte and the packet bytes.

On the receive side the framer takes bytes from a valid/ready stream. It reads the length byte and checks that the length lies in the legal window. It passes each packet byte onward with its index and accumulates the CRC as the bytes arrive. When the block ends it issues one result pulse. The pulse carries whether the CRC matched, whether the length was legal, and the packet length. The framer also holds the leading packet bytes as decoded header fields: an opcode byte, a one-byte first parameter and a two-byte second parameter. A downstream parser can read these without buffering the stream.

On the transmit side the framer takes a packet stream and its length. It sends the length byte first, then the packet bytes, then the CRC with the low byte first. An abort input, driven by an external inactivity timer, returns both directions to idle and produces no result.

Top module: `blk_framer`

## Requirements
- R1: After reset, res_valid, pkt_valid, tx_valid and tx_in_ready are low, rx_ready is high and the header fields read zero.
- R2: The length byte equals the packet length plus 3. On the receive side a legal block reports res_pkt_len = length byte − 3, with res_len_ok = 1. On the transmit side the first byte sent is tx_pkt_len + 3.
- R3: A received length byte below 4 or above 39 ends the block at once. The framer gives a result pulse with res_len_ok = 0, res_crc_ok = 0 and res_pkt_len = 0. It forwards no packet bytes, and the next byte received is taken as a new length byte.
- R4: The CRC starts at 0x0000. For each byte, bits 0 to 7 are fed in turn. For each bit, the feedback is the data bit XOR CRC bit 15; the CRC shifts left by one, and when the feedback is 1 it is XORed with 0x8005. The CRC covers the length and packet bytes. The low CRC byte travels before the high byte, and res_crc_ok = 1 only when both received CRC bytes match.
- R5: Each received block gives exactly one single-cycle res_valid pulse. The pulse comes in the cycle after the block's final byte is accepted, and rx_ready is low during the pulse.
- R6: Each packet byte, and no length or CRC byte, appears on pkt_data with pkt_valid high. It appears in the cycle the byte is accepted, and pkt_idx counts up from 0.
- R7: The opcode is packet byte 0 and param1 is byte 1. param2 is byte 2 in bits 7:0 and byte 3 in bits 15:8. Fields whose bytes are not present in the block read zero, because a legal length byte clears them.
- R8: The transmitter samples tx_pkt_len (1 to 36) when a packet starts. It emits the length byte, then the packet bytes, then the CRC low byte and the CRC high byte. tx_in_ready is high only while packet bytes are being sent and tx_ready is high.
- R9: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value.
- R10: Abort returns both directions to idle. A partly received block then produces no result, and tx_valid is low in the next cycle. The next block after an abort is framed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Inactivity abort; clears both directions |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Framer can accept a received byte |
| pkt_valid | output | 1 | A packet byte is being passed on |
| pkt_idx | output | 6 | Index of the packet byte |
| pkt_data | output | 8 | Packet byte |
| res_valid | output | 1 | Result pulse, one per received block |
| res_crc_ok | output | 1 | CRC matched |
| res_len_ok | output | 1 | Length byte was in the legal window |
| res_pkt_len | output | 6 | Packet length of the block |
| hdr_opcode | output | 8 | Packet byte 0 |
| hdr_param1 | output | 8 | Packet byte 1 |
| hdr_param2 | output | 16 | Packet bytes 2 (low) and 3 (high) |
| tx_in_valid | input | 1 | Outgoing packet byte valid |
| tx_in_data | input | 8 | Outgoing packet byte |
| tx_pkt_len | input | 6 | Outgoing packet length, sampled at packet start |
| tx_in_ready | output | 1 | Framer takes the outgoing packet byte |
| tx_valid | output | 1 | Framed byte valid |
| tx_data | output | 8 | Framed byte |
| tx_ready | input | 1 | Link accepts the framed byte |

## Verification
The hardest state to reach from the ports is an abort that lands partway through a block. The framer must drop the partial count and CRC without emitting a result, and then frame the next block correctly. The stimulus sends a length byte and a few packet bytes, raises abort for one cycle, waits, and then sends a full block that must check good. The same is done to a transmit block that is stalled partway through. The transmit path is also driven with a link that refuses every third cycle. This holds the framer in the length, packet and CRC phases while a byte is pending.

// File: rtl/blkfrm_pkg.sv
package blkfrm_pkg;

  typedef enum logic [1:0] {
    RX_LEN,
    RX_BODY,
    RX_CRC_LO,
    RX_CRC_HI
  } rx_state_e;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_LEN,
    TX_BODY,
    TX_CRC_LO,
    TX_CRC_HI
  } tx_state_e;

  // One byte into the CRC register, bit 0 first (R4).
  function automatic logic [15:0] crc_step(input logic [15:0] crc_in,
                                           input logic [7:0]  byte_in,
                                           input logic [15:0] poly);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = byte_in[i] ^ c[15];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/blkfrm_rx.sv
module blkfrm_rx
  import blkfrm_pkg::*;
#(
  parameter int          MIN_BLK = 4,
  parameter int          MAX_BLK = 39,
  parameter logic [15:0] POLY    = 16'h8005,
  parameter int          LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             abort,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             pkt_valid,
  output logic [LEN_W-1:0] pkt_idx,
  output logic [7:0]       pkt_data,
  output logic             res_valid,
  output logic             res_crc_ok,
  output logic             res_len_ok,
  output logic [LEN_W-1:0] res_pkt_len,
  output logic [7:0]       hdr_opcode,
  output logic [7:0]       hdr_param1,
  output logic [15:0]      hdr_param2
);

  localparam int OVERHEAD = 3;

  rx_state_e        state_q, state_d;
  logic [15:0]      crc_q, crc_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] plen_q, plen_d;
  logic [7:0]       clo_q, clo_d;
  logic [7:0]       op_q, op_d, p1_q, p1_d;
  logic [15:0]      p2_q, p2_d;
  logic             rv_q, rv_d, rc_q, rc_d, rl_q, rl_d;
  logic [LEN_W-1:0] rlen_q, rlen_d;
  logic             accept;
  logic             len_bad;

  assign rx_ready  = !abort && !rv_q;
  assign accept    = rx_valid && rx_ready;
  assign len_bad   = (rx_data < 8'(MIN_BLK)) || (rx_data > 8'(MAX_BLK));
  assign pkt_valid = accept && (state_q == RX_BODY);
  assign pkt_idx   = idx_q;
  assign pkt_data  = rx_data;

  always_comb begin
    state_d = state_q;
    crc_d   = crc_q;
    left_d  = left_q;
    idx_d   = idx_q;
    plen_d  = plen_q;
    clo_d   = clo_q;
    op_d    = op_q;
    p1_d    = p1_q;
    p2_d    = p2_q;
    rv_d    = 1'b0;
    rc_d    = rc_q;
    rl_d    = rl_q;
    rlen_d  = rlen_q;
    if (abort) begin
      state_d = RX_LEN;
    end else if (accept) begin
      unique case (state_q)
        RX_LEN: begin
          if (len_bad) begin
            rv_d   = 1'b1;
            rc_d   = 1'b0;
            rl_d   = 1'b0;
            rlen_d = '0;
          end else begin
            crc_d   = crc_step(16'h0000, rx_data, POLY);
            left_d  = LEN_W'(rx_data - 8'(OVERHEAD));
            plen_d  = LEN_W'(rx_data - 8'(OVERHEAD));
            idx_d   = '0;
            op_d    = '0;
            p1_d    = '0;
            p2_d    = '0;
            state_d = RX_BODY;
          end
        end
        RX_BODY: begin
          crc_d  = crc_step(crc_q, rx_data, POLY);
          idx_d  = idx_q + LEN_W'(1);
          left_d = left_q - LEN_W'(1);
          case (idx_q)
            LEN_W'(0): op_d       = rx_data;
            LEN_W'(1): p1_d       = rx_data;
            LEN_W'(2): p2_d[7:0]  = rx_data;
            LEN_W'(3): p2_d[15:8] = rx_data;
            default: ;
          endcase
          if (left_q == LEN_W'(1)) state_d = RX_CRC_LO;
        end
        RX_CRC_LO: begin
          clo_d   = rx_data;
          state_d = RX_CRC_HI;
        end
        RX_CRC_HI: begin
          rv_d    = 1'b1;
          rc_d    = ({rx_data, clo_q} == crc_q);
          rl_d    = 1'b1;
          rlen_d  = plen_q;
          state_d = RX_LEN;
        end
        default: state_d = RX_LEN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_LEN;
      crc_q   <= '0;
      left_q  <= '0;
      idx_q   <= '0;
      plen_q  <= '0;
      clo_q   <= '0;
      op_q    <= '0;
      p1_q    <= '0;
      p2_q    <= '0;
      rv_q    <= 1'b0;
      rc_q    <= 1'b0;
      rl_q    <= 1'b0;
      rlen_q  <= '0;
    end else begin
      state_q <= state_d;
      crc_q   <= crc_d;
      left_q  <= left_d;
      idx_q   <= idx_d;
      plen_q  <= plen_d;
      clo_q   <= clo_d;
      op_q    <= op_d;
      p1_q    <= p1_d;
      p2_q    <= p2_d;
      rv_q    <= rv_d;
      rc_q    <= rc_d;
      rl_q    <= rl_d;
      rlen_q  <= rlen_d;
    end
  end

  assign res_valid   = rv_q;
  assign res_crc_ok  = rc_q;
  assign res_len_ok  = rl_q;
  assign res_pkt_len = rlen_q;
  assign hdr_opcode  = op_q;
  assign hdr_param1  = p1_q;
  assign hdr_param2  = p2_q;

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    res_valid |=> !res_valid);

  assert_reject_clean_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (res_valid && !res_len_ok) |-> (!res_crc_ok && res_pkt_len == '0));

  assert_len_window_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (res_valid && res_len_ok) |->
      (res_pkt_len >= LEN_W'(MIN_BLK - OVERHEAD) && res_pkt_len <= LEN_W'(MAX_BLK - OVERHEAD)));

  assert_no_accept_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    res_valid |-> !pkt_valid);

endmodule

// File: rtl/blkfrm_tx.sv
module blkfrm_tx
  import blkfrm_pkg::*;
#(
  parameter int          MIN_BLK = 4,
  parameter int          MAX_BLK = 39,
  parameter logic [15:0] POLY    = 16'h8005,
  parameter int          LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             abort,
  input  logic             tx_in_valid,
  input  logic [7:0]       tx_in_data,
  input  logic [LEN_W-1:0] tx_pkt_len,
  output logic             tx_in_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready
);

  localparam int OVERHEAD = 3;

  tx_state_e        state_q, state_d;
  logic [7:0]       cnt_q, cnt_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [15:0]      crc_q, crc_d;

  always_comb begin
    tx_valid    = 1'b0;
    tx_data     = 8'h00;
    tx_in_ready = 1'b0;
    unique case (state_q)
      TX_LEN:    begin tx_valid = 1'b1; tx_data = cnt_q; end
      TX_BODY:   begin
        tx_valid    = tx_in_valid;
        tx_data     = tx_in_data;
        tx_in_ready = tx_ready;
      end
      TX_CRC_LO: begin tx_valid = 1'b1; tx_data = crc_q[7:0]; end
      TX_CRC_HI: begin tx_valid = 1'b1; tx_data = crc_q[15:8]; end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    crc_d   = crc_q;
    if (abort) begin
      state_d = TX_IDLE;
    end else begin
      unique case (state_q)
        TX_IDLE: if (tx_in_valid) begin
          cnt_d   = 8'(tx_pkt_len) + 8'(OVERHEAD);
          left_d  = tx_pkt_len;
          state_d = TX_LEN;
        end
        TX_LEN: if (tx_ready) begin
          crc_d   = crc_step(16'h0000, cnt_q, POLY);
          state_d = TX_BODY;
        end
        TX_BODY: if (tx_in_valid && tx_ready) begin
          crc_d  = crc_step(crc_q, tx_in_data, POLY);
          left_d = left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) state_d = TX_CRC_LO;
        end
        TX_CRC_LO: if (tx_ready) state_d = TX_CRC_HI;
        TX_CRC_HI: if (tx_ready) state_d = TX_IDLE;
        default:   state_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      crc_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
      crc_q   <= crc_d;
    end
  end

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_ni || abort)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_len_legal_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == TX_IDLE && tx_in_valid && !abort) |->
      (tx_pkt_len >= LEN_W'(MIN_BLK - OVERHEAD) && tx_pkt_len <= LEN_W'(MAX_BLK - OVERHEAD)));

  assert_take_needs_link_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_in_ready |-> tx_ready);

endmodule

// File: rtl/blk_framer.sv
module blk_framer
  import blkfrm_pkg::*;
#(
  parameter int          MIN_BLK = 4,
  parameter int          MAX_BLK = 39,
  parameter logic [15:0] POLY    = 16'h8005,
  localparam int         LEN_W   = $clog2(MAX_BLK - 3 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             pkt_valid,
  output logic [LEN_W-1:0] pkt_idx,
  output logic [7:0]       pkt_data,
  output logic             res_valid,
  output logic             res_crc_ok,
  output logic             res_len_ok,
  output logic [LEN_W-1:0] res_pkt_len,
  output logic [7:0]       hdr_opcode,
  output logic [7:0]       hdr_param1,
  output logic [15:0]      hdr_param2,
  input  logic             tx_in_valid,
  input  logic [7:0]       tx_in_data,
  input  logic [LEN_W-1:0] tx_pkt_len,
  output logic             tx_in_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  blkfrm_rx #(.MIN_BLK(MIN_BLK), .MAX_BLK(MAX_BLK), .POLY(POLY), .LEN_W(LEN_W)) u_rx (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .abort       (abort),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .pkt_valid   (pkt_valid),
    .pkt_idx     (pkt_idx),
    .pkt_data    (pkt_data),
    .res_valid   (res_valid),
    .res_crc_ok  (res_crc_ok),
    .res_len_ok  (res_len_ok),
    .res_pkt_len (res_pkt_len),
    .hdr_opcode  (hdr_opcode),
    .hdr_param1  (hdr_param1),
    .hdr_param2  (hdr_param2)
  );

  blkfrm_tx #(.MIN_BLK(MIN_BLK), .MAX_BLK(MAX_BLK), .POLY(POLY), .LEN_W(LEN_W)) u_tx (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .abort       (abort),
    .tx_in_valid (tx_in_valid),
    .tx_in_data  (tx_in_data),
    .tx_pkt_len  (tx_pkt_len),
    .tx_in_ready (tx_in_ready),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_ready    (tx_ready)
  );

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    abort |=> (!res_valid && !tx_valid));

endmodule

// File: tb/blk_framer_tb.sv
module blk_framer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        abort;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        pkt_valid;
  logic [5:0]  pkt_idx;
  logic [7:0]  pkt_data;
  logic        res_valid, res_crc_ok, res_len_ok;
  logic [5:0]  res_pkt_len;
  logic [7:0]  hdr_opcode, hdr_param1;
  logic [15:0] hdr_param2;
  logic        tx_in_valid;
  logic [7:0]  tx_in_data;
  logic [5:0]  tx_pkt_len;
  logic        tx_in_ready, tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;

  always #4 clk = ~clk;

  blk_framer u_dut (.*);

  int checks = 0;
  int errors = 0;

  // Each entry: {packet length, seed, corruption mode}; mode 0 none,
  // 1 CRC low byte flipped, 2 CRC high byte flipped, 3 packet byte flipped.
  localparam int NVEC = 8;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'd1,  8'h11, 2'd0},
    {8'd4,  8'h08, 2'd0},
    {8'd36, 8'hA5, 2'd0},
    {8'd13, 8'h40, 2'd1},
    {8'd7,  8'h3C, 2'd2},
    {8'd20, 8'h99, 2'd3},
    {8'd2,  8'h00, 2'd0},
    {8'd3,  8'hF0, 2'd0}
  };

  logic [7:0] blk [0:63];
  logic [7:0] pk_seen [0:63];
  int pk_cnt, pk_idx_err, res_cnt;
  logic cap_crc, cap_len_ok;
  logic [5:0] cap_len;

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c;
    logic fb;
    c = 16'h0000;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        fb = blk[k][b] ^ c[15];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8005;
      end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (res_valid) begin
    res_cnt++;
    cap_crc    = res_crc_ok;
    cap_len_ok = res_len_ok;
    cap_len    = res_pkt_len;
  end

  task automatic build(input int len, input logic [7:0] seed, input int mode);
    logic [15:0] c;
    blk[0] = 8'(len + 3);
    for (int i = 0; i < len; i++) blk[1+i] = 8'(seed + 8'(i * 7) + 8'(i >> 2));
    c = ref_crc(len + 1);
    blk[len+1] = c[7:0];
    blk[len+2] = c[15:8];
    if (mode == 1) blk[len+1] = blk[len+1] ^ 8'h01;
    if (mode == 2) blk[len+2] = blk[len+2] ^ 8'h80;
    if (mode == 3) blk[1] = blk[1] ^ 8'h10;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    #1;
    while (!rx_ready) begin
      @(negedge clk);
      #1;
    end
    if (pkt_valid) begin
      if (int'(pkt_idx) != pk_cnt) pk_idx_err++;
      pk_seen[pk_cnt] = pkt_data;
      pk_cnt++;
    end
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
  endtask

  task automatic rx_block(input int len, input int mode);
    int r0;
    bit pk_ok;
    logic [7:0] e_op, e_p1;
    logic [15:0] e_p2;
    r0 = res_cnt;
    pk_cnt = 0;
    pk_idx_err = 0;
    for (int i = 0; i < len + 3; i++) send_byte(blk[i]);
    @(negedge clk);
    @(negedge clk);
    check(res_cnt == r0 + 1, "R5 one result pulse", res_cnt - r0, 1);
    check(cap_crc == (mode == 0), "R4 crc_ok", int'(cap_crc), int'(mode == 0));
    check(cap_len_ok == 1'b1, "R2 len_ok", int'(cap_len_ok), 1);
    check(int'(cap_len) == len, "R2 packet length", int'(cap_len), len);
    pk_ok = (pk_cnt == len) && (pk_idx_err == 0);
    for (int i = 0; i < len; i++) if (pk_seen[i] != blk[1+i]) pk_ok = 0;
    check(pk_ok, "R6 packet bytes forwarded", pk_cnt, len);
    e_op = (len > 0) ? blk[1] : 8'h00;
    e_p1 = (len > 1) ? blk[2] : 8'h00;
    e_p2 = {(len > 3) ? blk[4] : 8'h00, (len > 2) ? blk[3] : 8'h00};
    check(hdr_opcode == e_op && hdr_param1 == e_p1 && hdr_param2 == e_p2,
          "R7 header fields", int'({hdr_opcode, hdr_param1, hdr_param2}),
          int'({e_op, e_p1, e_p2}));
  endtask

  task automatic tx_block(input int len, input bit stall);
    int fi, got, cyc, mism;
    logic [7:0] first;
    fi = 0; got = 0; cyc = 0; mism = 0; first = 8'h00;
    tx_pkt_len = 6'(len);
    while (got < len + 3 && cyc < 400) begin
      @(negedge clk);
      tx_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (fi < len) begin
        tx_in_valid = 1'b1;
        tx_in_data  = blk[1+fi];
      end else begin
        tx_in_valid = 1'b0;
      end
      #1;
      if (tx_valid && tx_ready) begin
        if (got == 0) first = tx_data;
        if (tx_data != blk[got]) mism++;
        got++;
      end
      if (tx_in_valid && tx_in_ready) fi++;
      cyc++;
    end
    tx_in_valid = 1'b0;
    tx_ready    = 1'b1;
    check(int'(first) == len + 3, "R2 tx length byte", int'(first), len + 3);
    check(got == len + 3 && mism == 0, "R8 tx framed block", mism, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    res_cnt = 0; pk_cnt = 0; pk_idx_err = 0;
    rst_n = 1'b0; abort = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    tx_in_valid = 1'b0; tx_in_data = 8'h00; tx_pkt_len = 6'd1; tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!res_valid && !pkt_valid && !tx_valid && !tx_in_ready && rx_ready,
          "R1 reset outputs", int'({res_valid, pkt_valid, tx_valid, tx_in_ready, rx_ready}), 1);
    check(hdr_opcode == 0 && hdr_param1 == 0 && hdr_param2 == 0,
          "R1 reset headers", int'({hdr_opcode, hdr_param1, hdr_param2}), 0);

    for (int v = 0; v < NVEC; v++) begin
      build(int'(VEC[v][17:10]), VEC[v][9:2], int'(VEC[v][1:0]));
      rx_block(int'(VEC[v][17:10]), int'(VEC[v][1:0]));
      build(int'(VEC[v][17:10]), VEC[v][9:2], 0);
      tx_block(int'(VEC[v][17:10]), v[0]);
    end

    // R3: illegal length bytes on both sides of the window
    foreach (blk[i]) blk[i] = 8'h00;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] badlen;
      badlen = (k == 0) ? 8'd3 : (k == 1) ? 8'd40 : (k == 2) ? 8'd0 : 8'd255;
      r0 = res_cnt;
      pk_cnt = 0;
      send_byte(badlen);
      @(negedge clk);
      @(negedge clk);
      check(res_cnt == r0 + 1 && !cap_len_ok && !cap_crc && cap_len == 0 && pk_cnt == 0,
            "R3 rejected length", int'({cap_len_ok, cap_crc, cap_len}), 0);
    end
    build(5, 8'h21, 0);
    rx_block(5, 0);

    // R10: abort in the middle of a received block
    r0 = res_cnt;
    send_byte(8'd10);
    send_byte(8'h08);
    send_byte(8'h01);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    repeat (4) @(negedge clk);
    check(res_cnt == r0, "R10 no result after abort", res_cnt - r0, 0);
    build(6, 8'h5A, 0);
    rx_block(6, 0);

    // R10: abort in the middle of a transmit block, link stalled
    build(10, 8'h77, 0);
    tx_ready = 1'b0;
    tx_pkt_len = 6'd10;
    @(negedge clk); tx_in_valid = 1'b1; tx_in_data = blk[1];
    repeat (2) @(negedge clk);
    #1;
    check(tx_valid == 1'b1, "R9 held while stalled", int'(tx_valid), 1);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0; tx_in_valid = 1'b0;
    #1;
    check(tx_valid == 1'b0, "R10 tx idle after abort", int'(tx_valid), 0);
    tx_ready = 1'b1;
    build(9, 8'h13, 0);
    tx_block(9, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule